// File: doc/BRIEF.md
# Atomic Set/Clear General-Purpose I/O Port

This block is a word-wide general-purpose I/O port for a set of pins that connect to external tristate pads. Every pin has an output value, a driver enable, and an input. Software never reads, edits and writes back the output or the enable state. It changes them only through four strobe registers. In each strobe register a 1 bit acts on the pin with the same index, and a 0 bit does nothing. One register raises outputs, one lowers them, one switches drivers on and one releases them.

The pad inputs are brought into the clock domain by a chain of synchronizer flops. They are then captured in a level register, which a read-only offset returns. The bus is a simple slave with address, write strobe, write data and read data. Read data is combinational on the address, so it is valid in the same cycle as the address. A write takes effect at the clock edge where the write strobe is sampled.

Top module: `gpio_sc_port`

## Requirements
- R1: A write to offset 0x00 sets `pin_out[n]` to 1 for every bit n that is 1 in the write data. The new value is visible after the clock edge that samples the write.
- R2: A write to offset 0x10 sets `pin_out[n]` to 0 for every bit n that is 1 in the write data.
- R3: A write to offset 0x20 sets `pin_oe[n]` to 1 (driver on) for every bit n that is 1 in the write data.
- R4: A write to offset 0x30 sets `pin_oe[n]` to 0 (pad released) for every bit n that is 1 in the write data.
- R5: In a write to any of the four strobe offsets, a bit that is 0 leaves the output value and the driver enable of that pin unchanged. Pins are independent, and bit n always maps to pin n.
- R6: While reset is high and after it is released, `pin_out` and `pin_oe` are all zero and the level register reads zero. Reset is synchronous and active high.
- R7: A read of offset 0x40 returns the level register in the same cycle. A value applied to `pin_in` before clock edge k first appears in the level register after edge k+2 (two synchronizer flops, then the level register).
- R8: Reads of every offset other than 0x40 return zero. Writes to offset 0x40, and to any address that is not one of the four strobe offsets, change neither `pin_out` nor `pin_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 8 | Byte address of the register accessed |
| bus_wr | input | 1 | Write strobe, sampled at the rising clock edge |
| bus_wdata | input | 32 | Write data, one bit per pin |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_out | output | 32 | Output value for each pad |
| pin_oe | output | 32 | Driver enable for each pad, 1 = drive |
| pin_in | input | 32 | Level seen at each pad, asynchronous |

## Verification
The per-pin assertions assume that the decoder never raises both the raise and the lower strobe for the same pin in one cycle, and likewise never both the enable and the release strobe. The bench keeps within this because it issues only one write per cycle on the single bus port. The synchronizer assertions make no assumption about `pin_in` timing. The bench still changes `pin_in` only at falling edges, so that the arrival cycle can be predicted exactly. Stimulus applies reset before any write and holds it over several edges.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    // Register offsets; software depends on these values
    localparam int unsigned OFS_RAISE   = 32'h00;
    localparam int unsigned OFS_LOWER   = 32'h10;
    localparam int unsigned OFS_DRV_ON  = 32'h20;
    localparam int unsigned OFS_DRV_OFF = 32'h30;
    localparam int unsigned OFS_LEVEL   = 32'h40;

    // Per-pin command produced by the decoder
    typedef struct packed {
        logic raise;
        logic lower;
        logic drv_on;
        logic drv_off;
    } pin_cmd_t;

    // Which register a bus address selects
    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_RAISE,
        SEL_LOWER,
        SEL_DRV_ON,
        SEL_DRV_OFF,
        SEL_LEVEL
    } reg_sel_t;

    function automatic reg_sel_t decode_addr(input int unsigned addr);
        reg_sel_t s;
        case (addr)
            OFS_RAISE:   s = SEL_RAISE;
            OFS_LOWER:   s = SEL_LOWER;
            OFS_DRV_ON:  s = SEL_DRV_ON;
            OFS_DRV_OFF: s = SEL_DRV_OFF;
            OFS_LEVEL:   s = SEL_LEVEL;
            default:     s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/gpio_bus_decode.sv
module gpio_bus_decode
    import gpio_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int WIDTH  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [WIDTH-1:0]  wdata,
    output pin_cmd_t          cmd [WIDTH],
    output logic              rd_level
);
    reg_sel_t sel;
    logic     hit_raise, hit_lower, hit_on, hit_off;

    always_comb begin
        sel       = decode_addr(int'(unsigned'(addr)));
        hit_raise = wr && (sel == SEL_RAISE);
        hit_lower = wr && (sel == SEL_LOWER);
        hit_on    = wr && (sel == SEL_DRV_ON);
        hit_off   = wr && (sel == SEL_DRV_OFF);
        rd_level  = (sel == SEL_LEVEL);
    end

    for (genvar g = 0; g < WIDTH; g++) begin : g_cmd
        always_comb begin
            cmd[g].raise   = hit_raise & wdata[g];
            cmd[g].lower   = hit_lower & wdata[g];
            cmd[g].drv_on  = hit_on    & wdata[g];
            cmd[g].drv_off = hit_off   & wdata[g];
        end
    end

    // R8: a single bus access selects at most one strobe register
    p_one_strobe_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({hit_raise, hit_lower, hit_on, hit_off}));

    // R8: no strobe fires without a write
    p_no_strobe_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !wr |-> !(hit_raise || hit_lower || hit_on || hit_off));

endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
    import gpio_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  pin_cmd_t cmd,
    output logic     out_q,
    output logic     oe_q
);
    logic out_d, oe_d;

    // Lowering beats raising, releasing beats enabling
    always_comb begin
        out_d = out_q;
        if (cmd.lower)      out_d = 1'b0;
        else if (cmd.raise) out_d = 1'b1;
        oe_d = oe_q;
        if (cmd.drv_off)     oe_d = 1'b0;
        else if (cmd.drv_on) oe_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= 1'b0;
            oe_q  <= 1'b0;
        end else begin
            out_q <= out_d;
            oe_q  <= oe_d;
        end
    end

    p_raise_r1: assert property (@(posedge clk) disable iff (rst)
        (cmd.raise && !cmd.lower) |=> out_q);
    p_lower_r2: assert property (@(posedge clk) disable iff (rst)
        cmd.lower |=> !out_q);
    p_drv_on_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd.drv_on && !cmd.drv_off) |=> oe_q);
    p_drv_off_r4: assert property (@(posedge clk) disable iff (rst)
        cmd.drv_off |=> !oe_q);
    p_out_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !(cmd.raise || cmd.lower) |=> $stable(out_q));
    p_oe_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !(cmd.drv_on || cmd.drv_off) |=> $stable(oe_q));
    p_reset_r6: assert property (@(posedge clk)
        rst |=> (!out_q && !oe_q));

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] level_q
);
    logic [WIDTH-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[0] <= '0;
                else     stg[0] <= pin_in;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[s] <= '0;
                else     stg[s] <= stg[s-1];
            end
            // R7: each synchronizer flop advances the previous one by one cycle
            p_stage_shift_r7: assert property (@(posedge clk) disable iff (rst)
                stg[s] == $past(stg[s-1]));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) level_q <= '0;
        else     level_q <= stg[STAGES-1];
    end

    p_first_stage_r7: assert property (@(posedge clk) disable iff (rst)
        stg[0] == $past(pin_in));
    p_level_capture_r7: assert property (@(posedge clk) disable iff (rst)
        level_q == $past(stg[STAGES-1]));
    p_level_reset_r6: assert property (@(posedge clk)
        rst |=> (level_q == '0));

endmodule

// File: rtl/gpio_sc_port.sv
module gpio_sc_port
    import gpio_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int WIDTH       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    output logic [WIDTH-1:0]  pin_out,
    output logic [WIDTH-1:0]  pin_oe,
    input  logic [WIDTH-1:0]  pin_in
);
    pin_cmd_t         cmd [WIDTH];
    logic             rd_level;
    logic [WIDTH-1:0] level;

    gpio_bus_decode #(.ADDR_W(ADDR_W), .WIDTH(WIDTH)) decode_i (
        .clk      (clk),
        .rst      (rst),
        .addr     (bus_addr),
        .wr       (bus_wr),
        .wdata    (bus_wdata),
        .cmd      (cmd),
        .rd_level (rd_level)
    );

    for (genvar g = 0; g < WIDTH; g++) begin : g_pin
        gpio_pin_cell cell_i (
            .clk   (clk),
            .rst   (rst),
            .cmd   (cmd[g]),
            .out_q (pin_out[g]),
            .oe_q  (pin_oe[g])
        );
    end

    gpio_in_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) sync_i (
        .clk     (clk),
        .rst     (rst),
        .pin_in  (pin_in),
        .level_q (level)
    );

    assign bus_rdata = rd_level ? level : '0;

    // R8: writes to the level offset leave the pin state alone
    p_level_write_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_W'(OFS_LEVEL)) |=> ($stable(pin_out) && $stable(pin_oe)));

endmodule

// File: tb/gpio_sc_port_tb_top.sv
module gpio_sc_port_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  bus_addr;
    logic        bus_wr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [31:0] pin_out, pin_oe, pin_in;

    int checks = 0;
    int failures = 0;
    logic [31:0] exp_out = '0;
    logic [31:0] exp_oe  = '0;

    always #4 clk = ~clk; // 125 MHz

    gpio_sc_port dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_out(pin_out), .pin_oe(pin_oe), .pin_in(pin_in)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // one write, applied at a falling edge; state is checked at the next falling edge
    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        case (a)
            8'h00: exp_out = exp_out | d;
            8'h10: exp_out = exp_out & ~d;
            8'h20: exp_oe  = exp_oe | d;
            8'h30: exp_oe  = exp_oe & ~d;
            default: ;
        endcase
        @(negedge clk);
        bus_wr = 1'b0;
        #1;
    endtask

    task automatic check_state(input string req);
        check({req, " pin_out"}, pin_out, exp_out);
        check({req, " pin_oe"}, pin_oe, exp_oe);
    endtask

    task automatic read_check(input string req, input logic [7:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : stim
        logic [31:0] pat;
        rst = 1'b1; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0; pin_in = 32'hFFFF_FFFF;
        repeat (4) @(negedge clk);
        #1;
        // R6: state during reset
        check("R6 out in reset", pin_out, 32'h0);
        check("R6 oe in reset", pin_oe, 32'h0);
        read_check("R6 level in reset", 8'h40, 32'h0);
        pin_in = '0;
        @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        #1;
        check_state("R6 after reset");
        read_check("R6 level after reset", 8'h40, 32'h0);

        // R1/R2: walk each bit high then low
        for (int i = 0; i < 32; i++) begin
            bus_write(8'h00, 32'h1 << i);
            check_state("R1 raise single bit");
        end
        for (int i = 0; i < 32; i++) begin
            bus_write(8'h10, 32'h1 << i);
            check_state("R2 lower single bit");
        end
        // R3/R4: walk drivers
        for (int i = 0; i < 32; i++) begin
            bus_write(8'h20, 32'h1 << i);
            check_state("R3 driver on single bit");
        end
        for (int i = 31; i >= 0; i--) begin
            bus_write(8'h30, 32'h1 << i);
            check_state("R4 driver off single bit");
        end

        // R5: mixed patterns, zero bits must hold
        for (int i = 0; i < 48; i++) begin
            pat = (i + 1) * 32'h9E37_79B9;
            pat = pat ^ (pat >> 13);
            bus_write(8'h10 * (i % 4), pat);
            check_state("R5 mixed pattern preserves zero bits");
        end
        bus_write(8'h00, 32'hA5A5_0F0F);
        bus_write(8'h20, 32'h3C3C_FF00);
        bus_write(8'h00, 32'h0);
        check_state("R5 all-zero raise no effect");
        bus_write(8'h10, 32'h0);
        bus_write(8'h30, 32'h0);
        check_state("R5 all-zero lower/release no effect");
        bus_write(8'h00, 32'hFFFF_FFFF);
        check_state("R1 raise all");
        bus_write(8'h10, 32'hFFFF_FFFF);
        check_state("R2 lower all");

        // R8: ignored writes
        bus_write(8'h00, 32'h1234_5678);
        bus_write(8'h40, 32'hFFFF_FFFF);
        check_state("R8 write to level offset ignored");
        bus_write(8'h04, 32'hFFFF_FFFF);
        check_state("R8 write to unmapped 0x04 ignored");
        bus_write(8'h50, 32'hFFFF_FFFF);
        check_state("R8 write to unmapped 0x50 ignored");
        bus_write(8'h90, 32'hFFFF_FFFF);
        check_state("R8 write to unmapped 0x90 ignored");

        // R7: input latency and level readback
        for (int i = 0; i < 8; i++) begin
            logic [31:0] old_lv;
            old_lv = (i == 0) ? 32'h0 : ((i) * 32'h6B43_A9B5) ^ 32'h0F0F_F0F0;
            pat = ((i + 1) * 32'h6B43_A9B5) ^ 32'h0F0F_F0F0;
            @(negedge clk);
            pin_in = pat;
            bus_addr = 8'h40;
            @(negedge clk); #1;
            check("R7 level unchanged after 1 edge", bus_rdata, old_lv);
            @(negedge clk); #1;
            check("R7 level unchanged after 2 edges", bus_rdata, old_lv);
            @(negedge clk); #1;
            check("R7 level updated after 3 edges", bus_rdata, pat);
            repeat (2) @(negedge clk);
            #1;
            check("R7 level stable", bus_rdata, pat);
        end

        // R8: reads elsewhere return zero while level is nonzero
        read_check("R8 read 0x00 zero", 8'h00, 32'h0);
        read_check("R8 read 0x10 zero", 8'h10, 32'h0);
        read_check("R8 read 0x20 zero", 8'h20, 32'h0);
        read_check("R8 read 0x30 zero", 8'h30, 32'h0);
        read_check("R8 read 0x44 zero", 8'h44, 32'h0);
        read_check("R8 read 0xC0 zero", 8'hC0, 32'h0);
        read_check("R7 read 0x40 level", 8'h40, ((8) * 32'h6B43_A9B5) ^ 32'h0F0F_F0F0);

        // R6: reset mid-run clears state
        bus_write(8'h00, 32'hFFFF_0000);
        bus_write(8'h20, 32'h00FF_FF00);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk); #1;
        exp_out = '0; exp_oe = '0;
        check_state("R6 reset mid-run");
        read_check("R6 level cleared by reset", 8'h40, 32'h0);
        @(negedge clk);
        rst = 1'b0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule